// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit register interface. Once enabled, it counts prescaled ticks through two chained timeout phases. When the first phase runs out, the block sets a pretimeout interrupt flag and locks its enable, so software can no longer stop it. When the second phase runs out, the block issues a single-cycle reset request on one of three lines. The reset-kind field selects the line.

Ticks come from a base prescaler of 2^BASE_EXP bus clock cycles. A two-bit logarithmic field stretches each tick by 1, 2, 4 or 8. A write to the kick register restarts both the prescaler and phase one. Software does this periodically to keep the system alive. Reset distribution, interrupt routing and clock generation lie outside this block.

Top module: `wdt_dual_phase`

## Requirements
- R1: After reset, the control word (word 2) reads 0x00000001, which means disabled with reset kind 1. The status word (word 1) reads 0. Both interrupt outputs and all three reset lines are low.
- R2: The control word fields are:
  - enable: bit 31
  - prescale: bits 30:29
  - phase-one limit P1: bits 26:22
  - phase-two limit P2: bits 19:15
  - reset kind: bits 1:0

  Every other bit reads 0. For example, writing 0x7FFFFFFF reads back 0x67CF8003.
- R3: Let T = 2^(BASE_EXP+prescale). Suppose enable becomes 1 at clock edge E, or a kick is taken at edge E. The phase-one flag (status bit 31, mirrored on `irq_phase1`) rises after edge E + (P1+1)·T. A limit value of 0 therefore still lasts one tick.
- R4: The phase-two flag (status bit 30, mirrored on `irq_phase2`) and the reset request both appear after edge E + (P1+P2+2)·T. The reset request is high for exactly one cycle, and no further request follows until reset.
- R5: The reset kind in effect at expiry chooses the line:
  - 0: `rst_chip`
  - 1: `rst_cpu`
  - 2: `rst_sw`
  - 3: `rst_chip`

  At most one line is high in any cycle.
- R6: Writing 1 to a status bit clears that flag. Writing 0 leaves the flag unchanged. If an expiry sets a flag in the same cycle that a write tries to clear it, the flag stays set.
- R7: Writing enable = 0 is ignored once phase one has expired. Before that point, clearing enable holds the counters at zero, and no flag rises. Re-enabling starts the timing of R3 afresh.
- R8: Writing a 1 to bit 31 of word 0 is a kick. It restarts the prescaler and phase one, even in a cycle where a phase would otherwise expire. It does not clear the status flags. Word 0 always reads 0.
- R9: A kick after the reset request has been issued has no effect. No flag rises again and no further reset request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for bus_en |
| bus_word | input | 2 | Word index (byte offset / 4): 0 kick, 1 status, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word (combinational) |
| irq_phase1 | output | 1 | Phase-one (pretimeout) flag level |
| irq_phase2 | output | 1 | Phase-two flag level |
| rst_chip | output | 1 | Whole-chip reset request pulse |
| rst_cpu | output | 1 | CPU-only reset request pulse |
| rst_sw | output | 1 | Software reset request pulse |

## Verification
Two pairs of functions can collide on the same clock edge, and the bench provokes each one deliberately.

The first pair is a phase expiry setting a status flag and a write-one-to-clear of that flag. The bench times the clearing write to land exactly on the computed phase-one expiry edge. It then expects the flag to remain set, and expects a later clear to succeed.

The second pair is a kick and an expiry. The bench lands a kick on the expiry edge and expects no flag that cycle. It then expects a full (P1+1)·T count measured from the kick edge.

// File: rtl/wdt_dp_pkg.sv
// Package: shared constants and types for the two-phase watchdog.
// Word indices, bit positions of register fields, reset kinds and the
// phase state encoding live here so every module decodes them identically.
package wdt_dp_pkg;

    localparam int DATA_W = 32;

    // word indices (byte offset / 4)
    localparam logic [1:0] W_KICK = 2'd0;
    localparam logic [1:0] W_STAT = 2'd1;
    localparam logic [1:0] W_CTRL = 2'd2;

    // control word field positions
    localparam int EN_BIT   = 31;
    localparam int PS_LSB   = 29;
    localparam int P1_LSB   = 22;
    localparam int P2_LSB   = 15;
    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 2;

    // kick and status bit positions
    localparam int KICK_BIT = 31;
    localparam int F1_BIT   = 31;
    localparam int F2_BIT   = 30;

    // reset kinds
    localparam logic [MODE_W-1:0] KIND_CHIP = 2'd0;
    localparam logic [MODE_W-1:0] KIND_CPU  = 2'd1;
    localparam logic [MODE_W-1:0] KIND_SW   = 2'd2;

    typedef enum logic [1:0] {
        ST_PH1  = 2'd0,
        ST_PH2  = 2'd1,
        ST_DONE = 2'd2
    } wdt_state_e;

endpackage

// File: rtl/wdt_dp_regs.sv
// Module: register file of the two-phase watchdog.
// Holds the control fields and the two sticky status flags, decodes kicks
// and returns read data combinationally.
// Assumes a single-cycle write strobe and a word index already derived from
// the byte address.
module wdt_dp_regs
    import wdt_dp_pkg::*;
#(
    parameter int PHASE_W = 5,
    parameter int PS_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [1:0]           bus_word,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 lock_i,
    input  logic                 ph1_set_i,
    input  logic                 ph2_set_i,
    output logic                 en_o,
    output logic [PS_W-1:0]      ps_o,
    output logic [PHASE_W-1:0]   p1_o,
    output logic [PHASE_W-1:0]   p2_o,
    output logic [MODE_W-1:0]    mode_o,
    output logic                 kick_o,
    output logic                 flag1_o,
    output logic                 flag2_o
);

    logic wr_any, wr_ctrl, wr_stat;
    logic unused_wdata;

    assign wr_any  = bus_en & bus_we;
    assign wr_ctrl = wr_any & (bus_word == W_CTRL);
    assign wr_stat = wr_any & (bus_word == W_STAT);
    assign kick_o  = wr_any & (bus_word == W_KICK) & bus_wdata[KICK_BIT];

    // bits with no field behind them
    assign unused_wdata = ^{bus_wdata[28:27], bus_wdata[21:20], bus_wdata[14:2]};

    // control fields; enable cannot drop while the engine holds the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            ps_o   <= '0;
            p1_o   <= '0;
            p2_o   <= '0;
            mode_o <= KIND_CPU;
        end else if (wr_ctrl) begin
            en_o   <= bus_wdata[EN_BIT] | lock_i;
            ps_o   <= bus_wdata[PS_LSB +: PS_W];
            p1_o   <= bus_wdata[P1_LSB +: PHASE_W];
            p2_o   <= bus_wdata[P2_LSB +: PHASE_W];
            mode_o <= bus_wdata[MODE_LSB +: MODE_W];
        end
    end

    // sticky status flags; a set in the same cycle beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1_o <= 1'b0;
            flag2_o <= 1'b0;
        end else begin
            flag1_o <= ph1_set_i | (flag1_o & ~(wr_stat & bus_wdata[F1_BIT]));
            flag2_o <= ph2_set_i | (flag2_o & ~(wr_stat & bus_wdata[F2_BIT]));
        end
    end

    // read multiplexer; unmapped bits and the kick word read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_word)
            W_STAT: begin
                bus_rdata[F1_BIT] = flag1_o;
                bus_rdata[F2_BIT] = flag2_o;
            end
            W_CTRL: begin
                bus_rdata[EN_BIT]                 = en_o;
                bus_rdata[PS_LSB +: PS_W]         = ps_o;
                bus_rdata[P1_LSB +: PHASE_W]      = p1_o;
                bus_rdata[P2_LSB +: PHASE_W]      = p2_o;
                bus_rdata[MODE_LSB +: MODE_W]     = mode_o;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_dp_tick_gen.sv
// Module: tick prescaler.
// Counts bus clocks and emits a one-cycle tick every 2^(BASE_EXP+ps) cycles.
// A clear input returns the count to zero; the first tick after a clear
// comes exactly one full period later.
module wdt_dp_tick_gen #(
    parameter int BASE_EXP = 25,
    parameter int PS_W     = 2,
    localparam int CW      = BASE_EXP + (1 << PS_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit  = (ONE << (BASE_EXP + int'(ps_i))) - ONE;
    assign tick_o = (cnt_q == limit);

    // divider count; wraps on tick, held at zero while cleared
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + ONE;
    end

endmodule

// File: rtl/wdt_dp_phase_engine.sv
// Module: phase sequencer.
// Counts ticks through phase one and phase two.
// On the phase-one expiry it pulses ph1_exp_o. On the phase-two expiry it
// pulses ph2_exp_o and registers a one-cycle reset request on the line the
// reset kind selects.
// After the request it parks in a final state until reset.
// Assumes en_i cannot fall while lock_o is high; the register file enforces
// that.
module wdt_dp_phase_engine
    import wdt_dp_pkg::*;
#(
    parameter int PHASE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               kick_i,
    input  logic               tick_i,
    input  logic [PHASE_W-1:0] p1_i,
    input  logic [PHASE_W-1:0] p2_i,
    input  logic [MODE_W-1:0]  mode_i,
    output logic               clr_div_o,
    output logic               lock_o,
    output logic               done_o,
    output logic               ph1_exp_o,
    output logic               ph2_exp_o,
    output logic               rst_chip_o,
    output logic               rst_cpu_o,
    output logic               rst_sw_o
);

    wdt_state_e         state_q;
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] cur_lim;
    logic               restart, advance, at_lim;

    assign done_o    = (state_q == ST_DONE);
    assign lock_o    = (state_q != ST_PH1);
    assign restart   = kick_i & ~done_o;
    assign cur_lim   = (state_q == ST_PH1) ? p1_i : p2_i;
    assign at_lim    = (cnt_q == cur_lim);
    assign advance   = en_i & ~restart & tick_i & ~done_o;
    assign clr_div_o = ~en_i | restart | done_o;
    assign ph1_exp_o = advance & at_lim & (state_q == ST_PH1);
    assign ph2_exp_o = advance & at_lim & (state_q == ST_PH2);

    // phase state and tick count within the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PH1;
            cnt_q   <= '0;
        end else if (!en_i || restart) begin
            state_q <= ST_PH1;
            cnt_q   <= '0;
        end else if (advance) begin
            if (at_lim) begin
                cnt_q   <= '0;
                state_q <= (state_q == ST_PH1) ? ST_PH2 : ST_DONE;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // one-cycle reset request, kind sampled at expiry; kind 3 maps to chip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_chip_o <= 1'b0;
            rst_cpu_o  <= 1'b0;
            rst_sw_o   <= 1'b0;
        end else begin
            rst_cpu_o  <= ph2_exp_o & (mode_i == KIND_CPU);
            rst_sw_o   <= ph2_exp_o & (mode_i == KIND_SW);
            rst_chip_o <= ph2_exp_o & (mode_i != KIND_CPU) & (mode_i != KIND_SW);
        end
    end

endmodule

// File: rtl/wdt_dual_phase.sv
// Module: top of the two-phase watchdog.
// Wires the register file, the tick prescaler and the phase sequencer.
// Assumes a synchronous active-low reset and a word-indexed register bus
// with combinational read data.
module wdt_dual_phase
    import wdt_dp_pkg::*;
#(
    parameter int BASE_EXP = 25,
    parameter int PHASE_W  = 5,
    parameter int PS_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_phase1,
    output logic              irq_phase2,
    output logic              rst_chip,
    output logic              rst_cpu,
    output logic              rst_sw
);

    logic               ctrl_en, kick, locked, is_done, tick, clr_div;
    logic               ph1_exp, ph2_exp;
    logic [PS_W-1:0]    ps;
    logic [PHASE_W-1:0] p1, p2;
    logic [MODE_W-1:0]  mode;

    wdt_dp_regs #(.PHASE_W(PHASE_W), .PS_W(PS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lock_i    (locked),
        .ph1_set_i (ph1_exp),
        .ph2_set_i (ph2_exp),
        .en_o      (ctrl_en),
        .ps_o      (ps),
        .p1_o      (p1),
        .p2_o      (p2),
        .mode_o    (mode),
        .kick_o    (kick),
        .flag1_o   (irq_phase1),
        .flag2_o   (irq_phase2)
    );

    wdt_dp_tick_gen #(.BASE_EXP(BASE_EXP), .PS_W(PS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_div),
        .ps_i   (ps),
        .tick_o (tick)
    );

    wdt_dp_phase_engine #(.PHASE_W(PHASE_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_en),
        .kick_i     (kick),
        .tick_i     (tick),
        .p1_i       (p1),
        .p2_i       (p2),
        .mode_i     (mode),
        .clr_div_o  (clr_div),
        .lock_o     (locked),
        .done_o     (is_done),
        .ph1_exp_o  (ph1_exp),
        .ph2_exp_o  (ph2_exp),
        .rst_chip_o (rst_chip),
        .rst_cpu_o  (rst_cpu),
        .rst_sw_o   (rst_sw)
    );

endmodule

// File: rtl/wdt_dual_phase_chk.sv
// Module: property checker for the two-phase watchdog, bound to the top.
// Observes enable, lock, kick, tick, expiry and the reset lines.
// Assumes BASE_EXP >= 1 so a cleared prescaler cannot tick in the next cycle.
module wdt_dual_phase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       kick,
    input logic       lock,
    input logic       done,
    input logic       tick,
    input logic       ph1_set,
    input logic       flag1,
    input logic [2:0] rst_vec
);

    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rst_vec)); // R5

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_vec) |=> !(|rst_vec)); // R4

    AST_RST_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_vec) |-> done); // R4

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lock) |=> en); // R7

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick); // R7

    AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !done) |=> (!tick && !lock)); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ph1_set |=> flag1); // R6

endmodule

bind wdt_dual_phase wdt_dual_phase_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .kick    (kick),
    .lock    (locked),
    .done    (is_done),
    .tick    (tick),
    .ph1_set (ph1_exp),
    .flag1   (irq_phase1),
    .rst_vec ({rst_chip, rst_cpu, rst_sw})
);

// File: tb/tb_wdt_dual_phase.sv
`timescale 1ns/1ps
// Bench: sweeps prescale, phase limits and reset kinds on a small base
// prescaler. Timing expectations come from (P1+1)*T and (P1+P2+2)*T.
module tb_wdt_dual_phase;

    localparam int B = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq1, irq2, rc, rp, rs;
    int          n_run = 0, n_fail = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    wdt_dual_phase #(.BASE_EXP(B)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_phase1(irq1), .irq_phase2(irq2),
        .rst_chip(rc), .rst_cpu(rp), .rst_sw(rs)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(int en, int ps, int p1, int p2, int mode);
        return (32'(en) << 31) | (32'(ps) << 29) | (32'(p1) << 22) | (32'(p2) << 15) | 32'(mode);
    endfunction

    // all tasks start and end at a falling edge
    task automatic do_reset();
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdw(input logic [1:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // from index 0 (just after the start edge), follow flag and reset lines
    task automatic watch(input int t1, input int t2, input int mode, input string lbl);
        int bad1 = -1, bad2 = -1;
        logic [2:0] got, expv, line;
        line = (mode == 1) ? 3'b010 : (mode == 2) ? 3'b001 : 3'b100;
        for (int i = 1; i <= t2 + 3; i++) begin
            @(negedge clk);
            if (irq1 !== (i >= t1) && bad1 < 0) bad1 = i;
            expv = (i == t2) ? line : 3'b000;
            got  = {rc, rp, rs};
            if ((got !== expv || irq2 !== (i >= t2)) && bad2 < 0) bad2 = i;
        end
        check(bad1 < 0, {"R3 phase-one flag timing ", lbl}, bad1, t1);
        check(bad2 < 0, {"R4 R5 reset pulse and phase-two flag ", lbl}, bad2, t2);
    endtask

    task automatic run_case(input int ps, input int p1, input int p2, input int mode);
        int t;
        t = 1 << (B + ps);
        do_reset();
        wr(2'd2, mk_ctrl(1, ps, p1, p2, mode));
        watch((p1 + 1) * t, (p1 + p2 + 2) * t, mode,
              $sformatf("ps=%0d p1=%0d p2=%0d kind=%0d", ps, p1, p2, mode));
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int k;
        int pl1 [4] = '{0, 2, 1, 4};
        int pl2 [4] = '{0, 1, 3, 0};
        int hits;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rdw(2'd2, rd); check(rd == 32'h1, "R1 control reset value", rd, 32'h1);
        rdw(2'd1, rd); check(rd == 32'h0, "R1 status reset value", rd, 0);
        check({irq1, irq2, rc, rp, rs} == 5'b0, "R1 outputs idle", {irq1, irq2, rc, rp, rs}, 0);

        // R2 field layout and read mask
        wr(2'd2, 32'h7FFF_FFFF);
        rdw(2'd2, rd); check(rd == 32'h67CF_8003, "R2 control read mask", rd, 32'h67CF_8003);

        // R8 kick word reads zero
        rdw(2'd0, rd); check(rd == 32'h0, "R8 kick word reads zero", rd, 0);

        // R3 R4 R5 sweep over prescale, limit pairs and kinds
        k = 0;
        for (int ps = 0; ps < 4; ps++) begin
            for (int j = 0; j < 4; j++) begin
                run_case(ps, pl1[j], pl2[j], k % 4);
                k++;
            end
        end
        run_case(0, 31, 31, 2);
        run_case(3, 31, 31, 3);

        // R6 set beats a same-cycle clear; write-0 ignored; write-1 clears
        do_reset();
        wr(2'd2, mk_ctrl(1, 0, 2, 0, 0));    // t1 = 48, t2 = 64
        wait_n(47);
        wr(2'd1, 32'h8000_0000);             // lands on the expiry edge
        check(irq1 == 1'b1, "R6 set wins over clear", irq1, 1);
        wr(2'd1, 32'h0);
        check(irq1 == 1'b1, "R6 write of 0 keeps flag", irq1, 1);
        wr(2'd1, 32'h8000_0000);
        check(irq1 == 1'b0, "R6 write of 1 clears flag", irq1, 0);
        wait_n(14);                          // index 64
        rdw(2'd1, rd); check(rd == 32'h4000_0000, "R6 status after phase two", rd, 32'h4000_0000);

        // R8 kick landing on the phase-one expiry edge wins
        do_reset();
        wr(2'd2, mk_ctrl(1, 0, 0, 0, 1));
        wait_n(15);
        wr(2'd0, 32'h8000_0000);
        watch(16, 32, 1, "R8 kick on expiry edge");

        // R8 kick during phase two restarts, flag one stays set
        do_reset();
        wr(2'd2, mk_ctrl(1, 1, 1, 3, 2));    // T = 32, t1 = 64
        wait_n(99);
        wr(2'd0, 32'h8000_0000);
        watch(0, 192, 2, "R8 kick in phase two");

        // R7 clearing enable before expiry stops the count
        do_reset();
        wr(2'd2, mk_ctrl(1, 0, 1, 0, 2));
        wait_n(10);
        wr(2'd2, mk_ctrl(0, 0, 1, 0, 2));
        rdw(2'd2, rd); check(rd[31] == 1'b0, "R7 enable clears before expiry", rd[31], 0);
        wait_n(100);
        check(irq1 == 1'b0, "R7 no flag while disabled", irq1, 0);
        wr(2'd2, mk_ctrl(1, 0, 1, 0, 2));
        watch(32, 48, 2, "R7 re-enable restarts");

        // R7 enable locked after phase-one expiry
        do_reset();
        wr(2'd2, mk_ctrl(1, 0, 0, 3, 1));    // t1 = 16, t2 = 80
        wait_n(20);
        wr(2'd2, mk_ctrl(0, 0, 0, 3, 1));    // now at index 21
        rdw(2'd2, rd); check(rd[31] == 1'b1, "R7 enable locked", rd[31], 1);
        hits = -1;
        for (int i = 22; i <= 82; i++) begin
            @(negedge clk);
            if (rp && hits < 0) hits = i;
        end
        check(hits == 80, "R7 reset still issued after disable attempt", hits, 80);

        // R9 kick after the request has no effect
        wr(2'd1, 32'hC000_0000);
        rdw(2'd1, rd); check(rd == 32'h0, "R6 both flags cleared", rd, 0);
        wr(2'd0, 32'h8000_0000);
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rc || rp || rs || irq1 || irq2) hits++;
        end
        check(hits == 0, "R9 kick after request ignored", hits, 0);
        rdw(2'd2, rd); check(rd[31] == 1'b1, "R9 enable still set", rd[31], 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule